// File: doc/BRIEF.md
# Flash access protection unit

This unit sits between two requesters, an embedded core and an external host, and the on-chip flash array, and decides for every request whether it reaches the array. When reset is released it first reads an 8-bit policy byte from a fixed location in the reserved information region. Until that byte is latched, no request is granted. The byte then sets the debug-port lock, the routing of the alternate reset input, the reset value of the clock unit's host lock, the reset value of the shared-memory top-address field, and whether the host may use the main region at all.

The main region is split into 8 KB blocks. Each block has a write-protect bit that firmware can program, and every one of these bits is set after reset. The lowest blocks, which form the core boot region, and the highest blocks, which form the host boot region, can never be written by the core. The information region is never written by anyone, and the host can neither read nor write it. A write that is refused is simply dropped and may raise a one-cycle interrupt. A host read that is refused returns all ones.

Top module: `flash_guard`

## Requirements
- R1: After reset, the unit reads the policy byte from information-region address `{1, PW_OFS}`, which is the low 8 bits of `fl_rdata` one cycle after the read. It raises `ready` two cycles after its internal reset releases. While `ready` is low, no grant is given and no flash write occurs. Until the byte is loaded, the decoded outputs take these values: debug locked, reset route disabled, clock lock 1, top address `FLASH_TOP`. The byte layout is: bits [2:0] debug code, [4:3] reset route, [5] clock-lock default, [6] top-address-zero, [7] host main-region enable.
- R2: A core read is never blocked, in either region. `c_rvalid` rises one cycle after the grant, with the flash data.
- R3: Each main-region block has a write-protect bit. All of these bits are 1 after reset. A pulse on `wp_we` loads `wp_val`. A core write to a block whose bit is 1 is refused.
- R4: A core write to any of the lowest `CBOOT_BLKS` blocks or the highest `HBOOT_BLKS` blocks is refused, whatever the write-protect bits say.
- R5: The information region is selected by address bit `AW-1` = 1. It is never written. Host reads of it return all ones, and host writes to it are dropped.
- R6: A refused write leaves `fl_en` low. A refused core write while `irq_en` is high pulses `viol_irq` for one cycle, in the following cycle.
- R7: `dbg_lock` is low only when the debug code is 111. `hold_reset` equals `dbg_lock` while `isp_mode` is low, and is 0 while `isp_mode` is high.
- R8: Reset route 01 drives `rst2_pin_a`, and 10 drives `rst2_pin_b`. Route 11 (disabled) and route 00 (reserved) drive neither.
- R9: `clk_lock_rst` equals the clock-lock bit. `top_addr_rst` is 0 when the top-address-zero bit is 1, and `FLASH_TOP` otherwise.
- R10: A host access to main-region block b proceeds only if the policy host-enable bit is 1 and bit b of the host mask is 1. The host mask is all ones after reset and is loaded by `hm_we`. A refused host read returns all ones one cycle later, and a refused host write is dropped.
- R11: The core has priority. When both requesters ask in the same cycle, only `c_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isp_mode | input | 1 | In-system programming environment active |
| irq_en | input | 1 | Enable for the violation interrupt |
| c_req | input | 1 | Core request |
| c_we | input | 1 | Core write |
| c_addr | input | AW | Core byte address |
| c_wdata | input | DW | Core write data |
| c_gnt | output | 1 | Core request taken |
| c_rvalid | output | 1 | Core read data valid |
| c_rdata | output | DW | Core read data |
| wp_we | input | 1 | Load write-protect bits |
| wp_val | input | NBLK | New write-protect bits |
| hm_we | input | 1 | Load host mask |
| hm_val | input | NBLK | New host mask |
| h_req | input | 1 | Host request |
| h_we | input | 1 | Host write |
| h_addr | input | AW | Host byte address |
| h_wdata | input | DW | Host write data |
| h_gnt | output | 1 | Host request taken |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | DW | Host read data (all ones if refused) |
| fl_en | output | 1 | Flash access strobe |
| fl_we | output | 1 | Flash write |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, one cycle after the read |
| ready | output | 1 | Policy byte loaded |
| viol_irq | output | 1 | Write-violation interrupt pulse |
| dbg_lock | output | 1 | Debug/parallel flash access locked |
| hold_reset | output | 1 | Keep device in reset |
| rst2_pin_a | output | 1 | Alternate reset on first pin |
| rst2_pin_b | output | 1 | Alternate reset on second pin |
| clk_lock_rst | output | 1 | Reset value of the clock-unit host lock |
| top_addr_rst | output | TW | Reset value of the shared-memory top-address field |

## Verification
Two conditions are hard to reach from the ports. The first is a write to a block that is both in a boot region and already cleared in the write-protect bits. To get there, the stimulus clears every protect bit first, so that only the boot rule can refuse the write. The second is the set of policy-byte variants, because each one only takes effect through a fresh reset. The stimulus therefore reloads the array model's policy byte and resets the unit several times, covering every route code and both states of the lock code. Dropped writes are observed as missing flash strobes and, depending on `irq_en`, as an interrupt or no interrupt in the next cycle.

// File: rtl/fg_pkg.sv
`timescale 1ns/1ps
package fg_pkg;

  typedef struct packed {
    logic       host_en;
    logic       top_zero;
    logic       clk_lock;
    logic [1:0] rst_route;
    logic [2:0] dbg_code;
  } pw_t;

  localparam pw_t PW_DEFAULT = '{host_en: 1'b0, top_zero: 1'b0, clk_lock: 1'b1,
                                 rst_route: 2'b11, dbg_code: 3'b000};

  typedef enum logic [1:0] {LD_RD, LD_CAP, LD_RUN} ld_state_t;

endpackage

// File: rtl/fg_loader.sv
`timescale 1ns/1ps
module fg_loader import fg_pkg::*; #(
  parameter int AW     = 17,
  parameter int PW_OFS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rd_byte,
  output logic          ld_en,
  output logic [AW-1:0] ld_addr,
  output logic          ready,
  output pw_t           pw
);

  ld_state_t st_q, st_d;
  pw_t       pw_q, pw_d;

  always_comb begin
    st_d = st_q;
    pw_d = pw_q;
    case (st_q)
      LD_RD:   st_d = LD_CAP;
      LD_CAP:  begin st_d = LD_RUN; pw_d = pw_t'(rd_byte); end
      default: st_d = LD_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LD_RD;
      pw_q <= PW_DEFAULT;
    end else begin
      st_q <= st_d;
      pw_q <= pw_d;
    end
  end

  assign ld_en   = (st_q == LD_RD);
  assign ld_addr = {1'b1, (AW-1)'(PW_OFS)};
  assign ready   = (st_q == LD_RUN);
  assign pw      = pw_q;

  // R1
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |=> ready);

endmodule

// File: rtl/fg_cfg.sv
`timescale 1ns/1ps
module fg_cfg #(
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wp_we,
  input  logic [NBLK-1:0] wp_val,
  input  logic            hm_we,
  input  logic [NBLK-1:0] hm_val,
  output logic [NBLK-1:0] wp_q,
  output logic [NBLK-1:0] hm_q
);

  logic [NBLK-1:0] wp_d, hm_d;

  always_comb begin
    wp_d = wp_we ? wp_val : wp_q;
    hm_d = hm_we ? hm_val : hm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '1;
      hm_q <= '1;
    end else begin
      wp_q <= wp_d;
      hm_q <= hm_d;
    end
  end

  // R3
  wp_load_chk: assert property (@(posedge clk) disable iff (!rst_n) wp_we |=> wp_q == $past(wp_val));

endmodule

// File: rtl/fg_policy.sv
`timescale 1ns/1ps
module fg_policy #(
  parameter int NBLK       = 8,
  parameter int BIW        = 3,
  parameter int CBOOT_BLKS = 1,
  parameter int HBOOT_BLKS = 1
) (
  input  logic            c_info,
  input  logic [BIW-1:0]  c_blk,
  input  logic            c_we,
  input  logic            h_info,
  input  logic [BIW-1:0]  h_blk,
  input  logic [NBLK-1:0] wp,
  input  logic [NBLK-1:0] hmask,
  input  logic            host_en,
  output logic            c_ok,
  output logic            h_ok
);

  logic [NBLK-1:0] boot_mask;

  for (genvar i = 0; i < NBLK; i++) begin : g_boot
    assign boot_mask[i] = (i < CBOOT_BLKS) || (i >= NBLK - HBOOT_BLKS);
  end

  always_comb begin
    c_ok = !c_we || (!c_info && !boot_mask[c_blk] && !wp[c_blk]);
    h_ok = !h_info && host_en && hmask[h_blk];
  end

endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard import fg_pkg::*; #(
  parameter int NBLK         = 8,
  parameter int BLK_AW       = 13,
  parameter int DW           = 16,
  parameter int CBOOT_BLKS   = 1,
  parameter int HBOOT_BLKS   = 1,
  parameter int PW_OFS       = 0,
  parameter int TW           = 4,
  parameter logic [TW-1:0] FLASH_TOP = TW'(8),
  localparam int BIW = $clog2(NBLK),
  localparam int AW  = BLK_AW + BIW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            isp_mode,
  input  logic            irq_en,
  input  logic            c_req,
  input  logic            c_we,
  input  logic [AW-1:0]   c_addr,
  input  logic [DW-1:0]   c_wdata,
  output logic            c_gnt,
  output logic            c_rvalid,
  output logic [DW-1:0]   c_rdata,
  input  logic            wp_we,
  input  logic [NBLK-1:0] wp_val,
  input  logic            hm_we,
  input  logic [NBLK-1:0] hm_val,
  input  logic            h_req,
  input  logic            h_we,
  input  logic [AW-1:0]   h_addr,
  input  logic [DW-1:0]   h_wdata,
  output logic            h_gnt,
  output logic            h_rvalid,
  output logic [DW-1:0]   h_rdata,
  output logic            fl_en,
  output logic            fl_we,
  output logic [AW-1:0]   fl_addr,
  output logic [DW-1:0]   fl_wdata,
  input  logic [DW-1:0]   fl_rdata,
  output logic            ready,
  output logic            viol_irq,
  output logic            dbg_lock,
  output logic            hold_reset,
  output logic            rst2_pin_a,
  output logic            rst2_pin_b,
  output logic            clk_lock_rst,
  output logic [TW-1:0]   top_addr_rst
);

  logic [1:0]      rs_q;
  logic            srst_n;
  logic            ld_en;
  logic [AW-1:0]   ld_addr;
  pw_t             pw;
  logic [NBLK-1:0] wp_q, hm_q;
  logic            c_ok, h_ok;
  logic            c_rv_q, h_rv_q, h_blk_q, irq_q;
  logic            c_rv_d, h_rv_d, h_blk_d, irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  fg_loader #(.AW(AW), .PW_OFS(PW_OFS)) u_loader (
    .clk(clk), .rst_n(srst_n), .rd_byte(fl_rdata[7:0]),
    .ld_en(ld_en), .ld_addr(ld_addr), .ready(ready), .pw(pw)
  );

  fg_cfg #(.NBLK(NBLK)) u_cfg (
    .clk(clk), .rst_n(srst_n), .wp_we(wp_we), .wp_val(wp_val),
    .hm_we(hm_we), .hm_val(hm_val), .wp_q(wp_q), .hm_q(hm_q)
  );

  fg_policy #(.NBLK(NBLK), .BIW(BIW), .CBOOT_BLKS(CBOOT_BLKS), .HBOOT_BLKS(HBOOT_BLKS)) u_policy (
    .c_info(c_addr[AW-1]), .c_blk(c_addr[AW-2:BLK_AW]), .c_we(c_we),
    .h_info(h_addr[AW-1]), .h_blk(h_addr[AW-2:BLK_AW]),
    .wp(wp_q), .hmask(hm_q), .host_en(pw.host_en), .c_ok(c_ok), .h_ok(h_ok)
  );

  assign c_gnt = ready && c_req;
  assign h_gnt = ready && h_req && !c_req;

  always_comb begin
    fl_en    = 1'b0;
    fl_we    = 1'b0;
    fl_addr  = ld_addr;
    fl_wdata = '0;
    if (!ready) begin
      fl_en = ld_en;
    end else if (c_gnt) begin
      fl_en    = c_ok;
      fl_we    = c_we && c_ok;
      fl_addr  = c_addr;
      fl_wdata = c_wdata;
    end else if (h_gnt) begin
      fl_en    = h_ok;
      fl_we    = h_we && h_ok;
      fl_addr  = h_addr;
      fl_wdata = h_wdata;
    end
  end

  always_comb begin
    c_rv_d  = c_gnt && !c_we;
    h_rv_d  = h_gnt && !h_we;
    h_blk_d = h_gnt && !h_ok;
    irq_d   = c_gnt && c_we && !c_ok && irq_en;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      c_rv_q  <= 1'b0;
      h_rv_q  <= 1'b0;
      h_blk_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      c_rv_q  <= c_rv_d;
      h_rv_q  <= h_rv_d;
      h_blk_q <= h_blk_d;
      irq_q   <= irq_d;
    end
  end

  assign c_rvalid = c_rv_q;
  assign c_rdata  = fl_rdata;
  assign h_rvalid = h_rv_q;
  assign h_rdata  = h_blk_q ? '1 : fl_rdata;
  assign viol_irq = irq_q;

  assign dbg_lock     = (pw.dbg_code != 3'b111);
  assign hold_reset   = dbg_lock && !isp_mode;
  assign rst2_pin_a   = (pw.rst_route == 2'b01);
  assign rst2_pin_b   = (pw.rst_route == 2'b10);
  assign clk_lock_rst = pw.clk_lock;
  assign top_addr_rst = pw.top_zero ? '0 : FLASH_TOP;

  // R1
  no_early_write_chk: assert property (@(posedge clk) disable iff (!srst_n) !ready |-> !fl_we);
  // R11
  single_grant_chk: assert property (@(posedge clk) disable iff (!srst_n) !(c_gnt && h_gnt));
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!srst_n)
    viol_irq |-> $past(c_gnt && c_we && !fl_en));
  // R5
  info_never_written_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fl_en && fl_we) |-> !fl_addr[AW-1]);
  // R4
  boot_ro_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (c_gnt && fl_we) |-> (int'(c_addr[AW-2:BLK_AW]) >= CBOOT_BLKS &&
                          int'(c_addr[AW-2:BLK_AW]) <  NBLK - HBOOT_BLKS));
  // R10
  host_ones_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (h_rvalid && h_rdata != '1) |-> $past(h_gnt && fl_en));

endmodule

// File: tb/flash_guard_tb_top.sv
`timescale 1ns/100ps
module flash_guard_tb_top;

  localparam int AW = 17;
  localparam int DW = 16;
  localparam int NB = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, isp_mode, irq_en;
  logic c_req, c_we, c_gnt, c_rvalid;
  logic [AW-1:0] c_addr, h_addr, fl_addr;
  logic [DW-1:0] c_wdata, c_rdata, h_wdata, h_rdata, fl_wdata, fl_rdata;
  logic wp_we, hm_we;
  logic [NB-1:0] wp_val, hm_val;
  logic h_req, h_we, h_gnt, h_rvalid;
  logic fl_en, fl_we, ready, viol_irq, dbg_lock, hold_reset;
  logic rst2_pin_a, rst2_pin_b, clk_lock_rst;
  logic [3:0] top_addr_rst;
  logic [7:0] pw_val;

  flash_guard dut_i (
    .clk(clk), .rst_n(rst_n), .isp_mode(isp_mode), .irq_en(irq_en),
    .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_gnt(c_gnt), .c_rvalid(c_rvalid), .c_rdata(c_rdata),
    .wp_we(wp_we), .wp_val(wp_val), .hm_we(hm_we), .hm_val(hm_val),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_gnt(h_gnt), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .fl_en(fl_en), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .ready(ready), .viol_irq(viol_irq),
    .dbg_lock(dbg_lock), .hold_reset(hold_reset), .rst2_pin_a(rst2_pin_a),
    .rst2_pin_b(rst2_pin_b), .clk_lock_rst(clk_lock_rst), .top_addr_rst(top_addr_rst)
  );

  function automatic logic [DW-1:0] model(logic [AW-1:0] a);
    return (a == 17'h10000) ? {8'h00, pw_val} : (a[15:0] ^ 16'h5A3C);
  endfunction

  // flash array model: one-cycle read latency
  always_ff @(posedge clk)
    if (fl_en && !fl_we) fl_rdata <= model(fl_addr);

  typedef struct {int kind; logic [63:0] val; string tag;} exp_t;
  exp_t sb_q[$];
  int total = 0, bad = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(int kind, logic [63:0] val, string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: 0 = flash write, 1 = core read data, 2 = host read data, 3 = interrupt
  task automatic observe(int kind, logic [63:0] val);
    exp_t e;
    total++;
    if (sb_q.size() == 0) begin
      bad++;
      $display("FAIL unexpected event kind=%0d actual=%0h expected=none", kind, val);
    end else begin
      e = sb_q.pop_front();
      if (e.kind != kind || e.val !== val) begin
        bad++;
        $display("FAIL %s actual=%0d:%0h expected=%0d:%0h", e.tag, kind, val, e.kind, e.val);
      end
    end
  endtask

  always begin
    @(negedge clk);
    #1.5;
    if (rst_n) begin
      if (fl_en && fl_we) observe(0, {fl_addr, fl_wdata});
      if (c_rvalid)       observe(1, 64'(c_rdata));
      if (h_rvalid)       observe(2, 64'(h_rdata));
      if (viol_irq)       observe(3, 64'd0);
    end
  end

  task automatic core_op(string tag, bit we, logic [AW-1:0] a, logic [DW-1:0] d,
                         bit pass, bit irq);
    @(negedge clk);
    c_req = 1'b1; c_we = we; c_addr = a; c_wdata = d;
    if (!we)      push(1, 64'(model(a)), tag);
    else if (pass) push(0, {a, d}, tag);
    if (irq)      push(3, 64'd0, tag);
    #1;
    chk({tag, " gnt"}, 64'(c_gnt), 64'd1);
    if (we && !pass) chk({tag, " dropped"}, 64'(fl_en), 64'd0);
    @(negedge clk);
    c_req = 1'b0; c_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_op(string tag, bit we, logic [AW-1:0] a, logic [DW-1:0] d, bit pass);
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = a; h_wdata = d;
    if (!we)       push(2, pass ? 64'(model(a)) : 64'hFFFF, tag);
    else if (pass) push(0, {a, d}, tag);
    #1;
    chk({tag, " gnt"}, 64'(h_gnt), 64'd1);
    if (!pass) chk({tag, " dropped"}, 64'(fl_en), 64'd0);
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain(string tag);
    repeat (3) @(negedge clk);
    chk({tag, " queue empty"}, 64'(sb_q.size()), 64'd0);
  endtask

  task automatic do_reset(logic [7:0] pw);
    @(negedge clk);
    rst_n = 1'b0; pw_val = pw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    c_req = 1'b1; c_we = 1'b1; c_addr = 17'h06000;
    #1;
    // R1: defaults before load, nothing granted
    chk("R1 ready low", 64'(ready), 64'd0);
    chk("R1 no grant", 64'(c_gnt), 64'd0);
    chk("R1 no write", 64'(fl_we), 64'd0);
    chk("R1 dbg locked", 64'(dbg_lock), 64'd1);
    chk("R1 route off", 64'({rst2_pin_a, rst2_pin_b}), 64'd0);
    chk("R1 clk lock", 64'(clk_lock_rst), 64'd1);
    @(negedge clk);
    c_req = 1'b0; c_we = 1'b0;
    for (int i = 0; i < 20 && !ready; i++) @(negedge clk);
    #1;
    chk("R1 ready", 64'(ready), 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; isp_mode = 1'b0; irq_en = 1'b1;
    c_req = 1'b0; c_we = 1'b0; c_addr = '0; c_wdata = '0;
    h_req = 1'b0; h_we = 1'b0; h_addr = '0; h_wdata = '0;
    wp_we = 1'b0; wp_val = '0; hm_we = 1'b0; hm_val = '0;
    pw_val = 8'hCF;

    // policy: code 111, route 01, clk lock 0, top zero 1, host enabled
    do_reset(8'hCF);
    chk("R7 unlocked", 64'(dbg_lock), 64'd0);
    chk("R7 no hold", 64'(hold_reset), 64'd0);
    chk("R8 route a", 64'({rst2_pin_a, rst2_pin_b}), 64'b10);
    chk("R9 clk lock 0", 64'(clk_lock_rst), 64'd0);
    chk("R9 top zero", 64'(top_addr_rst), 64'd0);

    core_op("R2 boot read", 1'b0, 17'h00100, 16'h0, 1'b0, 1'b0);
    core_op("R2 info read", 1'b0, 17'h10010, 16'h0, 1'b0, 1'b0);
    core_op("R3 reset-protected write", 1'b1, 17'h06000, 16'hBEEF, 1'b0, 1'b1);
    drain("R6");

    @(negedge clk); wp_we = 1'b1; wp_val = 8'h00;
    @(negedge clk); wp_we = 1'b0;
    core_op("R3 cleared write", 1'b1, 17'h06004, 16'h1234, 1'b1, 1'b0);
    core_op("R4 core boot write", 1'b1, 17'h00008, 16'h5555, 1'b0, 1'b1);
    irq_en = 1'b0;
    core_op("R4 host boot write", 1'b1, 17'h0E000, 16'h6666, 1'b0, 1'b0);
    core_op("R5 info write", 1'b1, 17'h10002, 16'h7777, 1'b0, 1'b0);
    @(negedge clk); wp_we = 1'b1; wp_val = 8'h08;
    @(negedge clk); wp_we = 1'b0;
    core_op("R3 block3 protected", 1'b1, 17'h06008, 16'h8888, 1'b0, 1'b0);
    core_op("R3 block4 open", 1'b1, 17'h08000, 16'h9999, 1'b1, 1'b0);
    drain("R6 no irq");

    host_op("R10 host read", 1'b0, 17'h06010, 16'h0, 1'b1);
    host_op("R10 host write", 1'b1, 17'h04000, 16'hA1A1, 1'b1);
    @(negedge clk); hm_we = 1'b1; hm_val = 8'hF7;
    @(negedge clk); hm_we = 1'b0;
    host_op("R10 masked read", 1'b0, 17'h06010, 16'h0, 1'b0);
    host_op("R10 masked write", 1'b1, 17'h06000, 16'hB2B2, 1'b0);
    host_op("R5 host info read", 1'b0, 17'h10000, 16'h0, 1'b0);
    host_op("R5 host info write", 1'b1, 17'h10004, 16'hC3C3, 1'b0);

    // R11: simultaneous requests
    @(negedge clk);
    c_req = 1'b1; c_we = 1'b0; c_addr = 17'h02000;
    h_req = 1'b1; h_we = 1'b0; h_addr = 17'h04000;
    push(1, 64'(model(17'h02000)), "R11 core wins");
    #1;
    chk("R11 core gnt", 64'(c_gnt), 64'd1);
    chk("R11 host held", 64'(h_gnt), 64'd0);
    @(negedge clk);
    c_req = 1'b0; h_req = 1'b0;
    drain("R11");

    // policy: code 101, route 11, clk lock 1, top from size, host disabled
    do_reset(8'h3D);
    chk("R7 locked", 64'(dbg_lock), 64'd1);
    chk("R7 hold", 64'(hold_reset), 64'd1);
    isp_mode = 1'b1;
    #0.5;
    chk("R7 isp release", 64'(hold_reset), 64'd0);
    isp_mode = 1'b0;
    chk("R8 route off", 64'({rst2_pin_a, rst2_pin_b}), 64'b00);
    chk("R9 clk lock 1", 64'(clk_lock_rst), 64'd1);
    chk("R9 top size", 64'(top_addr_rst), 64'd8);
    host_op("R10 host disabled", 1'b0, 17'h04000, 16'h0, 1'b0);
    drain("R10");

    // policy: code 011, route 10
    do_reset(8'h93);
    chk("R8 route b", 64'({rst2_pin_a, rst2_pin_b}), 64'b01);
    chk("R7 code 011 locked", 64'(dbg_lock), 64'd1);

    // policy: code 111, reserved route 00
    do_reset(8'h07);
    chk("R8 reserved route", 64'({rst2_pin_a, rst2_pin_b}), 64'b00);
    chk("R7 code 111", 64'(dbg_lock), 64'd0);
    drain("end");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule